// File: doc/BRIEF.md
# Priority Vector Resolver

This block sits beside an interrupt controller's register file and picks which source to report when software reads one of the two vector-status words. It receives one 64-bit vector of sources that are pending and enabled for the normal class, a second such vector for the fast class, and the 4-bit priority of every source packed into one flat bus. From these it forms a 32-bit status word for each class and holds it in a register, so each word follows its inputs with one clock of latency.

On the normal class the winner is the source with the numerically largest priority. Among equals, the higher source number wins. On the fast class the lowest-numbered active source wins and priority plays no part. When a read of either word is accepted, the block issues a one-cycle, one-hot request to clear the pending bit of the source it is reporting. Address decode and the storage of pending, enable and priority state belong to the surrounding controller.

Top module: `prio_vec_resolver`

## Requirements
- R1: The priority of source n is `prio_words[4n+3:4n]`. This is the same as nibble n mod 8 of 32-bit word n/8 when word w occupies `prio_words[32w+31:32w]`.
- R2: On the normal class, the active source with the numerically largest priority is reported.
- R3: When several active normal sources share the largest priority, the highest-numbered of them is reported.
- R4: A normal status word with a winner holds the source number in bits [31:16], zeros in bits [15:4] and the winner's priority in bits [3:0].
- R5: On the fast class, the lowest-numbered active source is reported. The status word is that number zero-extended to 32 bits.
- R6: With no active source in a class, that class's status word is 0xFFFFFFFF, and a read of it produces no clear request.
- R7: A clear output has exactly one bit set, at the reported source's position. It is active only in a cycle where that class's read strobe is high and a winner is reported. Otherwise it is all zeros.
- R8: A priority-0 source is reported when it is the only active normal source.
- R9: Each status word reflects the activity vector and priorities sampled at the previous rising clock edge.
- R10: While reset is asserted, and until the first clock edge after its release, both status words read 0xFFFFFFFF and both clear outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_act | input | 64 | Pending and enabled normal-class sources |
| fast_act | input | 64 | Pending and enabled fast-class sources |
| prio_words | input | 256 | Packed 4-bit priorities, source n at bits [4n+3:4n] |
| norm_rd | input | 1 | Read of the normal status word accepted this cycle |
| fast_rd | input | 1 | Read of the fast status word accepted this cycle |
| norm_status | output | 32 | Registered normal-class status word |
| fast_status | output | 32 | Registered fast-class status word |
| norm_clr | output | 64 | One-hot clear request for the reported normal source |
| fast_clr | output | 64 | One-hot clear request for the reported fast source |

## Verification
The assertions take for granted that the activity vectors are driven to known values from reset onward. This matters because the checks on the clear outputs compare them against the vectors sampled one cycle earlier. They also assume that a read strobe reports the word currently registered, so that a clear names a source that was active at the previous edge. The stimulus changes inputs only on the falling clock edge and holds each pattern for at least one full cycle before it samples results. Read strobes are raised for a single cycle after the status word has settled. The bench leaves the activity vectors alone in response to a clear, because pending storage lies outside this block.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int NSRC     = 64;
  localparam int PW       = 4;
  localparam int IDXW     = $clog2(NSRC);
  localparam int STAT_W   = 32;
  localparam int HALF_W   = STAT_W / 2;

  typedef struct packed {
    logic            found;
    logic [IDXW-1:0] idx;
    logic [PW-1:0]   prio;
  } pick_t;
endpackage

// File: rtl/pvr_norm_pick.sv
module pvr_norm_pick
  import pvr_pkg::*;
#(
  parameter int N = NSRC,
  parameter int P = PW
) (
  input  logic [N-1:0]   act,
  input  logic [N*P-1:0] prio_flat,
  output pick_t          pick
);
  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++) begin
      // ">=" while scanning upward: the later (higher-numbered) equal wins
      if (act[i] && (!pick.found || (prio_flat[i*P +: P] >= pick.prio))) begin
        pick.found = 1'b1;
        pick.idx   = IDXW'(i);
        pick.prio  = prio_flat[i*P +: P];
      end
    end
  end
endmodule

// File: rtl/pvr_fast_pick.sv
module pvr_fast_pick
  import pvr_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0] act,
  output pick_t        pick
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        pick.found = 1'b1;
        pick.idx   = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/pvr_clr_gen.sv
module pvr_clr_gen
  import pvr_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic            found,
  input  logic [IDXW-1:0] idx,
  output logic [N-1:0]    clr
);
  always_comb begin
    clr = '0;
    for (int i = 0; i < N; i++) begin
      clr[i] = rd && found && (idx == IDXW'(i));
    end
  end

  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  // R7
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (clr == '0));
endmodule

// File: rtl/prio_vec_resolver.sv
module prio_vec_resolver
  import pvr_pkg::*;
#(
  parameter int N = NSRC,
  parameter int P = PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   norm_act,
  input  logic [N-1:0]   fast_act,
  input  logic [N*P-1:0] prio_words,
  input  logic           norm_rd,
  input  logic           fast_rd,
  output logic [31:0]    norm_status,
  output logic [31:0]    fast_status,
  output logic [N-1:0]   norm_clr,
  output logic [N-1:0]   fast_clr
);
  localparam logic [STAT_W-1:0] NONE = '1;

  pick_t norm_d, norm_q, fast_d, fast_q;
  logic  upd_en;

  pvr_norm_pick #(.N(N), .P(P)) u_norm (
    .act(norm_act), .prio_flat(prio_words), .pick(norm_d));
  pvr_fast_pick #(.N(N)) u_fast (
    .act(fast_act), .pick(fast_d));

  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= '0;
      fast_q <= '0;
    end else if (upd_en) begin
      norm_q <= norm_d;
      fast_q <= fast_d;
    end
  end

  always_comb begin
    norm_status = NONE;
    fast_status = NONE;
    if (norm_q.found)
      norm_status = {{(HALF_W-IDXW){1'b0}}, norm_q.idx,
                     {(HALF_W-P){1'b0}}, norm_q.prio};
    if (fast_q.found)
      fast_status = {{(STAT_W-IDXW){1'b0}}, fast_q.idx};
  end

  pvr_clr_gen #(.N(N)) u_nclr (
    .clk(clk), .rst_n(rst_n), .rd(norm_rd),
    .found(norm_q.found), .idx(norm_q.idx), .clr(norm_clr));
  pvr_clr_gen #(.N(N)) u_fclr (
    .clk(clk), .rst_n(rst_n), .rd(fast_rd),
    .found(fast_q.found), .idx(fast_q.idx), .clr(fast_clr));

  // R6
  norm_none_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_status == NONE) |-> (norm_clr == '0));
  // R6
  fast_none_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_status == NONE) |-> (fast_clr == '0));
  // R9
  norm_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_clr != '0) |-> (($past(norm_act) & norm_clr) != '0));
  // R5
  fast_clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr != '0) |-> ((($past(fast_act) & fast_clr) != '0) &&
                          (($past(fast_act) & (fast_clr - 1'b1)) == '0)));
endmodule

// File: tb/prio_vec_resolver_tb.sv
module prio_vec_resolver_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [63:0]  norm_act, fast_act;
  logic [255:0] prio_words;
  logic         norm_rd, fast_rd;
  logic [31:0]  norm_status, fast_status;
  logic [63:0]  norm_clr, fast_clr;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prio_vec_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .norm_act(norm_act), .fast_act(fast_act),
    .prio_words(prio_words), .norm_rd(norm_rd), .fast_rd(fast_rd),
    .norm_status(norm_status), .fast_status(fast_status),
    .norm_clr(norm_clr), .fast_clr(fast_clr));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_norm(logic [63:0] a, logic [255:0] pw);
    int best = -1;
    int win = -1;
    for (int i = 63; i >= 0; i--) begin
      int p = int'(pw[4*i +: 4]);
      if (a[i] && p > best) begin best = p; win = i; end
    end
    if (win < 0) return 32'hFFFF_FFFF;
    return {16'(win), 12'h000, 4'(best)};
  endfunction

  function automatic logic [31:0] ref_fast(logic [63:0] a);
    for (int i = 0; i < 64; i++) if (a[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [255:0] set_prio(logic [255:0] pw, int src, logic [3:0] p);
    logic [255:0] r = pw;
    r[32*(src/8) + 4*(src%8) +: 4] = p;
    return r;
  endfunction

  // drive at negedge, let one rising edge register it, sample at next negedge
  task automatic apply(logic [63:0] na, logic [63:0] fa, logic [255:0] pw);
    @(negedge clk);
    norm_act = na; fast_act = fa; prio_words = pw;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; norm_act = '1; fast_act = '1; prio_words = '1;
    norm_rd = 1'b1; fast_rd = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 norm_status", 64'(norm_status), 64'hFFFF_FFFF);
    chk("R10 fast_status", 64'(fast_status), 64'hFFFF_FFFF);
    chk("R10 norm_clr", norm_clr, '0);
    chk("R10 fast_clr", fast_clr, '0);
    norm_rd = 1'b0; fast_rd = 1'b0; norm_act = '0; fast_act = '0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_layout();
    logic [255:0] pw = '0;
    pw = set_prio(pw, 13, 4'h9);
    apply(64'(1) << 13, '0, pw);
    chk("R1 layout src13 word1 nibble5", 64'(norm_status), 64'h000D_0009);
    chk("R4 upper/middle fields", 64'(norm_status[15:4]), 64'h0);
  endtask

  task automatic t_largest();
    logic [255:0] pw = '0;
    pw = set_prio(pw, 2, 4'h3); pw = set_prio(pw, 40, 4'hE); pw = set_prio(pw, 63, 4'h7);
    apply((64'(1) << 2) | (64'(1) << 40) | (64'(1) << 63), '0, pw);
    chk("R2 largest priority", 64'(norm_status), 64'h0028_000E);
  endtask

  task automatic t_tie();
    logic [255:0] pw = '0;
    pw = set_prio(pw, 5, 4'hA); pw = set_prio(pw, 33, 4'hA); pw = set_prio(pw, 20, 4'h4);
    apply((64'(1) << 5) | (64'(1) << 33) | (64'(1) << 20), '0, pw);
    chk("R3 tie to higher number", 64'(norm_status), 64'h0021_000A);
    pw = '1;
    apply('1, '0, pw);
    chk("R3 all equal max", 64'(norm_status), 64'h003F_000F);
  endtask

  task automatic t_prio0();
    apply(64'(1) << 0, '0, '0);
    chk("R8 lone priority-0 src0", 64'(norm_status), 64'h0000_0000);
    apply(64'(1) << 47, '0, '0);
    chk("R8 lone priority-0 src47", 64'(norm_status), 64'h002F_0000);
  endtask

  task automatic t_fast();
    apply('0, (64'(1) << 9) | (64'(1) << 50), '1);
    chk("R5 fast lowest", 64'(fast_status), 64'd9);
    apply('0, 64'(1) << 63, '0);
    chk("R5 fast top", 64'(fast_status), 64'd63);
  endtask

  task automatic t_none();
    apply('0, '0, '1);
    chk("R6 norm none", 64'(norm_status), 64'hFFFF_FFFF);
    chk("R6 fast none", 64'(fast_status), 64'hFFFF_FFFF);
    norm_rd = 1'b1; fast_rd = 1'b1; #1;
    chk("R6 norm no clear", norm_clr, '0);
    chk("R6 fast no clear", fast_clr, '0);
    @(negedge clk); norm_rd = 1'b0; fast_rd = 1'b0;
  endtask

  task automatic t_clear();
    logic [255:0] pw = '0;
    pw = set_prio(pw, 17, 4'h6);
    apply(64'(1) << 17, (64'(1) << 4) | (64'(1) << 30), pw);
    #1;
    chk("R7 no clear without read", norm_clr | fast_clr, '0);
    norm_rd = 1'b1; fast_rd = 1'b1; #1;
    chk("R7 norm clear one-hot", norm_clr, 64'(1) << 17);
    chk("R7 fast clear one-hot", fast_clr, 64'(1) << 4);
    @(negedge clk); norm_rd = 1'b0; fast_rd = 1'b0; #1;
    chk("R7 clear single cycle", norm_clr | fast_clr, '0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    norm_act = 64'(1) << 8; fast_act = 64'(1) << 3; prio_words = '0;
    @(posedge clk); #1;
    chk("R9 norm after edge", 64'(norm_status), 64'h0008_0000);
    chk("R9 fast after edge", 64'(fast_status), 64'd3);
  endtask

  task automatic t_random();
    for (int k = 0; k < 200; k++) begin
      logic [63:0] na, fa;
      logic [255:0] pw;
      na = {$urandom, $urandom}; fa = {$urandom, $urandom};
      if (k % 3 == 1) begin na &= {$urandom, $urandom}; na &= {$urandom, $urandom}; end
      if (k % 4 == 2) begin fa &= {$urandom, $urandom} & {$urandom, $urandom}; end
      for (int w = 0; w < 8; w++) pw[32*w +: 32] = $urandom;
      if (k % 5 == 0) pw &= {8{32'h3333_3333}};
      apply(na, fa, pw);
      chk("R2 R3 random normal", 64'(norm_status), 64'(ref_norm(na, pw)));
      chk("R5 random fast", 64'(fast_status), 64'(ref_fast(fa)));
    end
  endtask

  initial begin
    t_reset();
    t_layout();
    t_largest();
    t_tie();
    t_prio0();
    t_fast();
    t_none();
    t_clear();
    t_latency();
    t_random();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule